// File: doc/BRIEF.md
# Floating-Point Pending-Operation Queue

This block records floating-point operations that have been launched but have not yet finished, so that a trap handler can recover exact information about them after a floating-point exception. Each accepted issue pushes an instruction address and an instruction word at the tail. In normal running, completion pulses retire entries from the head in launch order.

A fault input freezes the queue. While frozen, the queue keeps its contents, refuses new issues and ignores completions. The handler then sends drain requests. Each request pops the oldest entry and shows it on the drain outputs for one cycle. The frozen state ends only when the queue has been emptied this way. Status outputs report empty, full and frozen. A completion that arrives while the queue is empty is flagged.

Top module: `fp_pending_queue`

## Requirements
- R1: After reset the queue is empty and not frozen. empty_o=1, full_o=0, frozen_o=0, issue_ready_o=1, drain_valid_o=0, retire_err_o=0.
- R2: issue_ready_o is 1 exactly when the queue is neither frozen nor full. An issue with issue_valid_i=1 and issue_ready_o=1 appends {issue_pc_i, issue_insn_i} at the tail, and empty_o reflects it from the next cycle.
- R3: full_o is 1 when DEPTH entries are held (default 4). An issue attempted while full is refused and leaves the contents unchanged.
- R4: A retire_i pulse while not frozen and not empty removes the oldest entry, so entries leave in the order they were issued.
- R5: An accepted issue and a retire in the same cycle leave the entry count unchanged.
- R6: A retire_i pulse while not frozen and empty sets retire_err_o for exactly the following cycle. Any issue in that same cycle is still accepted.
- R7: fault_i sets frozen_o from the next cycle. Contents are kept, and issue_ready_o is 0 while frozen. An issue or retire in the cycle fault_i is sampled still takes effect.
- R8: While frozen, retire_i has no effect on the contents and raises no error.
- R9: A drain_req_i while frozen and not empty pops the oldest entry. In the following cycle drain_valid_o=1, and drain_pc_o/drain_insn_o carry that entry. Otherwise drain_valid_o=0 and both data outputs are zero.
- R10: A drain_req_i while frozen clears frozen_o from the next cycle if it pops the last entry, or if the queue was already empty.
- R11: drain_req_i while not frozen has no effect.
- R12: fault_i takes priority: if fault_i is sampled in the same cycle as an unfreezing drain, the queue stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation launch request |
| issue_pc_i | input | 32 | Address of launched instruction |
| issue_insn_i | input | 32 | Instruction word of launched instruction |
| issue_ready_o | output | 1 | Launch accepted when high |
| retire_i | input | 1 | Completion pulse, retires oldest entry |
| fault_i | input | 1 | Floating-point exception, freezes queue |
| drain_req_i | input | 1 | Handler request to pop one entry |
| drain_valid_o | output | 1 | Drained entry presented this cycle |
| drain_pc_o | output | 32 | Address of drained entry |
| drain_insn_o | output | 32 | Instruction word of drained entry |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds DEPTH entries |
| frozen_o | output | 1 | Queue frozen after exception |
| retire_err_o | output | 1 | Completion arrived with empty queue |

## Verification
Directed phases come first. The queue is filled past its depth, which separates refused issues from accepted ones. Retires are then run down to empty and one past it, which exposes ordering and error flagging. A same-cycle issue with retire checks count accounting. Freezing with a partly filled queue, then issuing, retiring and draining, distinguishes frozen behaviour from normal behaviour. It also confirms that the drained order matches the launch order. Freezes are also tried on an empty queue and together with the last drain, which checks how unfreezing and fault priority interact. A long stretch of mixed random traffic then compares every output with the reference model each cycle.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned INSN_W = 32;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [INSN_W-1:0] insn;
  } fpq_entry_t;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/fpq_store.sv
module fpq_store
  import fpq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  fpq_entry_t       wr_data_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output fpq_entry_t       rd_data_o
);
  fpq_entry_t slots_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        slots_q[g] <= '0;
      else if (wr_en_i && wr_ptr_i == PTR_W'(g))          slots_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slots_q[rd_ptr_i];
endmodule

// File: rtl/fpq_ctrl.sv
module fpq_ctrl
  import fpq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             retire_i,
  input  logic             fault_i,
  input  logic             drain_req_i,
  output logic             issue_ready_o,
  output logic             push_o,
  output logic             drain_pop_o,
  output logic             retire_err_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frozen_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             frozen_q, frozen_d;
  logic             err_q;
  logic             is_empty, is_full, norm_pop, pop;

  assign is_empty      = (cnt_q == '0);
  assign is_full       = (cnt_q == CNT_W'(DEPTH));
  assign issue_ready_o = !frozen_q && !is_full;
  assign push_o        = issue_valid_i && issue_ready_o;
  assign norm_pop      = retire_i && !frozen_q && !is_empty;
  assign drain_pop_o   = drain_req_i && frozen_q && !is_empty;
  assign pop           = norm_pop || drain_pop_o;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(push_o) - CNT_W'(pop);
    frozen_d = frozen_q;
    if (fault_i)
      frozen_d = 1'b1;
    else if (frozen_q && drain_req_i && cnt_q <= CNT_W'(1))
      frozen_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      frozen_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (push_o) wr_ptr_q <= PTR_W'(wrap_inc(int'(wr_ptr_q), DEPTH));
      if (pop)    rd_ptr_q <= PTR_W'(wrap_inc(int'(rd_ptr_q), DEPTH));
      cnt_q    <= cnt_d;
      frozen_q <= frozen_d;
      err_q    <= retire_i && !frozen_q && is_empty;
    end
  end

  assign wr_ptr_o     = wr_ptr_q;
  assign rd_ptr_o     = rd_ptr_q;
  assign cnt_o        = cnt_q;
  assign frozen_o     = frozen_q;
  assign retire_err_o = err_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_full && !pop) |=> cnt_q == CNT_W'(DEPTH));
  p_frozen_retire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && retire_i && !drain_req_i) |=> (cnt_q == $past(cnt_q)) && !err_q);
  p_unfreeze_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frozen_q) |-> cnt_q == '0);
  p_fault_freezes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> frozen_q);
  p_swap_keeps_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && norm_pop) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/fp_pending_queue.sv
module fp_pending_queue
  import fpq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [PC_W-1:0]   issue_pc_i,
  input  logic [INSN_W-1:0] issue_insn_i,
  output logic              issue_ready_o,
  input  logic              retire_i,
  input  logic              fault_i,
  input  logic              drain_req_i,
  output logic              drain_valid_o,
  output logic [PC_W-1:0]   drain_pc_o,
  output logic [INSN_W-1:0] drain_insn_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              frozen_o,
  output logic              retire_err_o
);
  logic             push, drain_pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  fpq_entry_t       wr_entry, head_entry, drain_q;
  logic             drain_valid_q;

  assign wr_entry = '{pc: issue_pc_i, insn: issue_insn_i};

  fpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .issue_valid_i, .retire_i, .fault_i, .drain_req_i,
    .issue_ready_o,
    .push_o       (push),
    .drain_pop_o  (drain_pop),
    .retire_err_o,
    .wr_ptr_o     (wr_ptr),
    .rd_ptr_o     (rd_ptr),
    .cnt_o        (cnt),
    .frozen_o
  );

  fpq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (push),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_entry),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (head_entry)
  );

  // one-cycle presentation of the popped entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_valid_q <= 1'b0;
      drain_q       <= '0;
    end else begin
      drain_valid_q <= drain_pop;
      drain_q       <= drain_pop ? head_entry : '0;
    end
  end

  assign drain_valid_o = drain_valid_q;
  assign drain_pc_o    = drain_q.pc;
  assign drain_insn_o  = drain_q.insn;
  assign empty_o       = (cnt == '0);
  assign full_o        = (cnt == CNT_W'(DEPTH));

  p_drain_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && drain_req_i && !empty_o) |=> drain_valid_o);
  p_drain_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_o |=> !drain_valid_o);
  p_err_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && empty_o && !frozen_o) |=> retire_err_o);
  p_ready_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o || full_o) |-> !issue_ready_o);
endmodule

// File: tb/fp_pending_queue_test.sv
module fp_pending_queue_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0, rt = 1'b0, flt = 1'b0, dr = 1'b0;
  logic [31:0] ipc = '0, iinsn = '0;
  logic        ready, dv, empty, full, frozen, err;
  logic [31:0] dpc, dinsn;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1 reset";

  always #2 clk = ~clk;

  fp_pending_queue #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(iv), .issue_pc_i(ipc), .issue_insn_i(iinsn), .issue_ready_o(ready),
    .retire_i(rt), .fault_i(flt), .drain_req_i(dr),
    .drain_valid_o(dv), .drain_pc_o(dpc), .drain_insn_o(dinsn),
    .empty_o(empty), .full_o(full), .frozen_o(frozen), .retire_err_o(err)
  );

  // behavioural reference
  logic [63:0] mq[$];
  bit          mfrz, merr, mdv, nf;
  logic [63:0] mdd;
  int          n0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mfrz = 0; merr = 0; mdv = 0; mdd = '0;
    end else begin
      bit rdy;
      rdy = !mfrz && mq.size() < DEPTH;
      n0 = mq.size();
      merr = 0; mdv = 0; mdd = '0; nf = mfrz;
      if (!mfrz && rt) begin
        if (n0 == 0) merr = 1; else void'(mq.pop_front());
      end
      if (mfrz && dr) begin
        if (n0 > 0) begin mdv = 1; mdd = mq.pop_front(); end
        if (n0 <= 1) nf = 0;
      end
      if (iv && rdy) mq.push_back({ipc, iinsn});
      mfrz = flt ? 1'b1 : nf;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 R3 R7 issue_ready", 64'(ready), 64'(!mfrz && mq.size() < DEPTH));
    chk("R2 empty", 64'(empty), 64'(mq.size() == 0));
    chk("R3 full", 64'(full), 64'(mq.size() == DEPTH));
    chk("R7 R10 R12 frozen", 64'(frozen), 64'(mfrz));
    chk("R6 retire_err", 64'(err), 64'(merr));
    chk("R9 R11 drain_valid", 64'(dv), 64'(mdv));
    chk("R9 drain_data", {dpc, dinsn}, mdd);
  endtask

  int seq = 0;
  task automatic cyc(bit i, bit r, bit f, bit d);
    iv = i; rt = r; flt = f; dr = d;
    seq++;
    ipc = 32'h1000_0000 + 32'(seq) * 4; iinsn = 32'h8000_0000 ^ (32'(seq) * 32'h9E37);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  bit done = 0;
  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                           // R1 reset state
    rst_n = 1'b1;
    @(negedge clk); compare();
    phase = "R2 R3 fill past depth";
    for (int k = 0; k < DEPTH + 2; k++) cyc(1, 0, 0, 0);
    phase = "R4 in-order retire";
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    phase = "R5 issue with retire";
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    phase = "R6 retire to empty and past";
    for (int k = 0; k < DEPTH + 1; k++) cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 0);                     // error plus accepted issue
    phase = "R11 drain while running";
    cyc(0, 0, 0, 1); cyc(1, 0, 0, 1);
    phase = "R7 freeze with issue in same cycle";
    cyc(1, 0, 1, 0);
    phase = "R7 R8 frozen issue and retire";
    cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(1, 1, 0, 0);
    phase = "R9 R10 drain in order";
    for (int k = 0; k < DEPTH; k++) cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 0);
    phase = "R10 freeze empty then drain";
    cyc(0, 1, 1, 0); cyc(0, 0, 0, 1); cyc(1, 0, 0, 0);
    phase = "R12 fault with last drain";
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    phase = "R4 R9 mixed random traffic";
    for (int k = 0; k < 600; k++) begin
      bit f;
      f = ($urandom_range(0, 39) == 0);
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), f,
          1'($urandom_range(0, 2) == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule